// File: doc/BRIEF.md
# MDIO Paged Register Bridge

This block is a management slave on a clause-22 MDIO bus that opens a 32-bit register space behind a 16-bit serial link. The two upper bits of the 5-bit PHY address in each frame select what the frame means. It can set a page, move one 16-bit half of a 32-bit register, or go to an internal PHY. A page frame stores a 10-bit page. A register frame joins that page with the remaining PHY address bits and the register field to form a 19-bit byte address. The block then drives a plain parallel register bus with single-cycle read and write strobes.

The MDC and MDIO pins are oversampled in the system clock domain. The bit engine checks for a preamble and a start pattern, decodes the header, and turns the pin around for reads. A 32-bit write is split across two frames. The upper half is parked first, and a single bus write fires when the lower half arrives. This lets a trigger bit in the lower half see a complete word. A read of the lower half fetches the whole word and keeps the upper half as a snapshot for a later upper-half read. Bypass frames never touch the register bus. They only raise a pass-through pulse.

Top module: `mdio_page_bridge`

## Requirements
- R1: PHY address bits [4:3] select the mode: 3 is page select, 2 is register access, 0 is bypass, and 1 is ignored (no pin drive, no bus access, no pulse).
- R2: A page-select write stores write data bits [9:0] as the page, which becomes bus address bits [18:9].
- R3: In register mode the byte address is {page, PHY address [2:0], register field [4:0], 0}. The bus address is that value with bits [1:0] forced to zero.
- R4: A register-mode write with register field bit 0 set (upper half) only holds its 16 bits and issues no bus write.
- R5: A register-mode write with register field bit 0 clear (lower half) issues exactly one bus write of {held upper half, new lower half}.
- R6: A register-mode read of the lower half issues exactly one bus read and returns bus data bits [15:0].
- R7: A register-mode read of the upper half returns bits [31:16] captured at the last lower-half read and issues no bus read.
- R8: A read in page-select mode returns 0xFFFF and issues no bus access.
- R9: Any frame in bypass mode gives a one-cycle pass-through pulse. A bypass read returns 0xFFFF. Bypass frames issue no bus access.
- R10: Reset clears the page and the upper-half holding register, and releases the MDIO pin.
- R11: A frame is accepted only after at least 32 consecutive ones followed by start bits 0,1. Opcode 01 is a write and 10 is a read. Any other opcode is ignored.
- R12: On a read the pin stays released for the first turnaround bit, drives 0 for the second, then drives 16 data bits MSB first, and is released after the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples MDC |
| rstN | input | 1 | Active-low synchronous reset |
| mdc | input | 1 | Management clock from the host |
| mdioIn | input | 1 | MDIO pin input value |
| mdioOut | output | 1 | MDIO value driven by the slave |
| mdioOe | output | 1 | MDIO output enable |
| bypassHit | output | 1 | One-cycle pulse for a bypass-mode frame |
| regWr | output | 1 | Bus write strobe |
| regRd | output | 1 | Bus read strobe; data is taken in the same cycle |
| regAddr | output | 19 | Bus byte address, bits [1:0] zero |
| regWdata | output | 32 | Bus write data |
| regRdata | input | 32 | Bus read data |

## Verification
The bench targets the split write. A design that committed on the upper half, or that dropped the held half, would show a bus write after the first frame or a wrong upper word. For reads, the bench changes the bus data between a lower-half read and an upper-half read. A bridge that re-reads the bus instead of using the snapshot then returns the new value. The bench also checks that reset clears the page and the holding register, since a stale page shows up directly in the address bits. It checks turnaround polarity, a short preamble, an unused mode and page readback, where a careless decoder would drive the pin or touch the bus.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;
  localparam int HDR_W = 12;
  localparam int HALF_W = 16;
  localparam int PAGE_W = 10;

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_IGNORE = 2'd1,
    MODE_REG    = 2'd2,
    MODE_PAGE   = 2'd3
  } modeT;

  // control to datapath strobes
  typedef struct packed {
    logic decode;   // header complete, frame accepted
    logic commit;   // write data complete
    logic advance;  // shift read data by one bit
    logic drive;    // slave owns the pin
  } strobeT;
endpackage

// File: rtl/mdio_bridge_ctrl.sv
module mdio_bridge_ctrl
  import mdio_bridge_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mdc,
  input  logic              mdioIn,
  output strobeT            strb,
  output logic [HDR_W-1:0]  hdr,
  output logic [HALF_W-1:0] wdata
);
  localparam int PRE_W = $clog2(PRE_LEN + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_HDR, S_TA, S_DATA} stateT;

  stateT             state;
  logic [2:0]        mdcSync;
  logic [1:0]        mdioSync;
  logic [PRE_W-1:0]  preCnt;
  logic [3:0]        bitCnt;
  logic [HDR_W-1:0]  hdrShift;
  logic              frameOk;
  logic              isRead;

  logic              rise;
  logic              bitIn;
  logic [HDR_W-1:0]  hdrNext;
  logic [HALF_W-1:0] dataNext;
  logic              opValid;

  assign rise     = mdcSync[1] & ~mdcSync[2];
  assign bitIn    = mdioSync[1];
  assign hdrNext  = {hdrShift[HDR_W-2:0], bitIn};
  assign dataNext = {wdata[HALF_W-2:0], bitIn};
  assign opValid  = (hdrNext[11:10] == 2'b01) || (hdrNext[11:10] == 2'b10);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mdcSync  <= '0;
      mdioSync <= '1;
      state    <= S_IDLE;
      preCnt   <= '0;
      bitCnt   <= '0;
      hdrShift <= '0;
      hdr      <= '0;
      wdata    <= '0;
      frameOk  <= 1'b0;
      isRead   <= 1'b0;
      strb     <= '0;
    end else begin
      mdcSync      <= {mdcSync[1:0], mdc};
      mdioSync     <= {mdioSync[0], mdioIn};
      strb.decode  <= 1'b0;
      strb.commit  <= 1'b0;
      strb.advance <= 1'b0;
      if (rise) begin
        case (state)
          S_IDLE: begin
            if (bitIn) begin
              if (preCnt < PRE_W'(PRE_LEN)) preCnt <= preCnt + 1'b1;
            end else begin
              if (preCnt >= PRE_W'(PRE_LEN)) state <= S_START;
              preCnt <= '0;
            end
          end
          S_START: begin
            state  <= bitIn ? S_HDR : S_IDLE;
            bitCnt <= '0;
          end
          S_HDR: begin
            hdrShift <= hdrNext;
            bitCnt   <= bitCnt + 1'b1;
            if (bitCnt == 4'd11) begin
              hdr         <= hdrNext;
              frameOk     <= opValid && (hdrNext[9:8] != MODE_IGNORE);
              strb.decode <= opValid && (hdrNext[9:8] != MODE_IGNORE);
              isRead      <= hdrNext[11:10] == 2'b10;
              state       <= S_TA;
              bitCnt      <= '0;
            end
          end
          S_TA: begin
            if (bitCnt == 4'd0) begin
              bitCnt <= 4'd1;
              if (frameOk && isRead) strb.drive <= 1'b1;
            end else begin
              strb.advance <= 1'b1;
              state        <= S_DATA;
              bitCnt       <= '0;
            end
          end
          S_DATA: begin
            wdata  <= dataNext;
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt != 4'd15) begin
              strb.advance <= 1'b1;
            end else begin
              strb.drive  <= 1'b0;
              strb.commit <= frameOk && !isRead;
              state       <= S_IDLE;
              preCnt      <= '0;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mdio_bridge_dp.sv
module mdio_bridge_dp
  import mdio_bridge_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [HDR_W-1:0]  hdr,
  input  logic [HALF_W-1:0] wdata,
  output logic              mdioOut,
  output logic              bypassHit,
  output logic              regWr,
  output logic              regRd,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] regRdata
);
  modeT              mode;
  logic              isRead;
  logic              upperHalf;
  logic [PAGE_W-1:0] page;
  logic [HALF_W-1:0] holdHi;
  logic [HALF_W-1:0] snapHi;
  logic [HALF_W:0]   readShift;
  logic [HALF_W-1:0] readVal;

  assign mode      = modeT'(hdr[9:8]);
  assign isRead    = hdr[11:10] == 2'b10;
  assign upperHalf = hdr[0];

  assign regAddr   = {page, hdr[7:5], hdr[4:1], 2'b00};
  assign regWdata  = {holdHi, wdata};
  assign regRd     = strb.decode && isRead && (mode == MODE_REG) && !upperHalf;
  assign regWr     = strb.commit && (mode == MODE_REG) && !upperHalf;
  assign bypassHit = strb.decode && (mode == MODE_BYPASS);
  assign mdioOut   = readShift[HALF_W];

  always_comb begin
    readVal = '1;
    if (mode == MODE_REG) readVal = upperHalf ? snapHi : regRdata[HALF_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      page      <= '0;
      holdHi    <= '0;
      snapHi    <= '0;
      readShift <= '1;
    end else begin
      if (strb.decode) begin
        readShift <= {1'b0, readVal};
        if (regRd) snapHi <= regRdata[DATA_W-1:HALF_W];
      end else if (strb.advance) begin
        readShift <= {readShift[HALF_W-1:0], 1'b1};
      end
      if (strb.commit) begin
        if (mode == MODE_PAGE) page <= wdata[PAGE_W-1:0];
        if (mode == MODE_REG && upperHalf) holdHi <= wdata;
      end
    end
  end
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int DATA_W  = 32,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mdc,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              mdioOe,
  output logic              bypassHit,
  output logic              regWr,
  output logic              regRd,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] regRdata
);
  strobeT            strb;
  logic [HDR_W-1:0]  hdr;
  logic [HALF_W-1:0] wdata;

  mdio_bridge_ctrl #(.PRE_LEN(PRE_LEN)) i_ctrl (
    .clk(clk), .rstN(rstN), .mdc(mdc), .mdioIn(mdioIn),
    .strb(strb), .hdr(hdr), .wdata(wdata)
  );

  mdio_bridge_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .hdr(hdr), .wdata(wdata),
    .mdioOut(mdioOut), .bypassHit(bypassHit), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata)
  );

  assign mdioOe = strb.drive;
endmodule

// File: rtl/mdio_page_bridge_checker.sv
module mdio_page_bridge_checker (
  input logic clk,
  input logic rstN,
  input logic mdioOut,
  input logic mdioOe,
  input logic bypassHit,
  input logic regWr,
  input logic regRd
);
  // a write commits only after the pin is free (no read in flight)
  assert_wr_idle_pin_R5: assert property (@(posedge clk) disable iff (!rstN)
    regWr |-> !mdioOe);

  // bus strobes never overlap
  assert_no_rd_wr_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && regRd));

  // a bus read is a single-cycle strobe
  assert_rd_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    regRd |=> !regRd);

  // bypass frames never reach the register bus
  assert_bypass_no_bus_R9: assert property (@(posedge clk) disable iff (!rstN)
    bypassHit |-> (!regWr && !regRd));

  // turnaround: the first driven bit is zero
  assert_ta_low_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdioOe) |-> !mdioOut);

  // drive starts no sooner than a cycle after a bus read
  assert_drive_after_read_R12: assert property (@(posedge clk) disable iff (!rstN)
    regRd |=> !$rose(mdioOe));
endmodule

bind mdio_page_bridge mdio_page_bridge_checker i_checker (
  .clk(clk), .rstN(rstN), .mdioOut(mdioOut), .mdioOe(mdioOe),
  .bypassHit(bypassHit), .regWr(regWr), .regRd(regRd)
);

// File: tb/test_mdio_page_bridge.sv
`timescale 1ns/1ps
module test_mdio_page_bridge;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mdc = 1'b0;
  logic        mdioIn = 1'b1;
  logic        mdioOut, mdioOe, bypassHit, regWr, regRd;
  logic [18:0] regAddr;
  logic [31:0] regWdata;
  logic [31:0] busWord = 32'h0;

  int tests = 0;
  int fails = 0;
  int wrCount = 0, rdCount = 0, bypCount = 0;
  logic [18:0] lastWrAddr = '0, lastRdAddr = '0;
  logic [31:0] lastWrData = '0;

  always #2.5 clk = ~clk;

  mdio_page_bridge i_mdio_page_bridge (
    .clk(clk), .rstN(rstN), .mdc(mdc), .mdioIn(mdioIn),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .bypassHit(bypassHit),
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(busWord)
  );

  always @(posedge clk) begin
    if (regWr) begin wrCount++; lastWrAddr = regAddr; lastWrData = regWdata; end
    if (regRd) begin rdCount++; lastRdAddr = regAddr; end
    if (bypassHit) bypCount++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mdcBit(input logic b, output logic so, output logic sOe);
    mdioIn = b;
    mdc = 1'b0;
    repeat (4) @(negedge clk);
    so = mdioOut;
    sOe = mdioOe;
    mdc = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // one full frame; rd collects the slave's data, taOk reports turnaround
  task automatic frame(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] wd, input int pre,
                       output logic [15:0] rd, output logic taOk, output logic anyOe);
    logic so, sOe;
    logic [13:0] head;
    head = {2'b01, op, phy, rg};
    rd = '0; taOk = 1'b1; anyOe = 1'b0;
    for (int i = 0; i < pre; i++) begin mdcBit(1'b1, so, sOe); anyOe |= sOe; end
    for (int i = 13; i >= 0; i--) begin mdcBit(head[i], so, sOe); anyOe |= sOe; end
    if (op == 2'b10) begin
      mdcBit(1'b1, so, sOe); anyOe |= sOe;
      if (sOe) taOk = 1'b0;
      mdcBit(1'b1, so, sOe); anyOe |= sOe;
      if (!sOe || so) taOk = 1'b0;
      for (int i = 15; i >= 0; i--) begin
        mdcBit(1'b1, so, sOe); anyOe |= sOe;
        rd[i] = sOe ? so : 1'b1;
      end
    end else begin
      mdcBit(1'b1, so, sOe); anyOe |= sOe;
      mdcBit(1'b0, so, sOe); anyOe |= sOe;
      for (int i = 15; i >= 0; i--) begin mdcBit(wd[i], so, sOe); anyOe |= sOe; end
    end
    mdioIn = 1'b1;
    mdc = 1'b0;
    repeat (8) @(negedge clk);
    if (mdioOe) taOk = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic testReset();
    doReset();
    chk("R10 pin released", {31'd0, mdioOe}, 32'd0);
    chk("R10 no strobes", {30'd0, regWr, regRd}, 32'd0);
  endtask

  task automatic testSplitWrite();
    logic [15:0] rd; logic ta, oe; int w0;
    frame(2'b01, 5'b11_000, 5'd0, 16'hF2A5, 32, rd, ta, oe);
    w0 = wrCount;
    frame(2'b01, 5'b10_101, 5'b01101, 16'hBEEF, 32, rd, ta, oe);
    chk("R4 no write on upper half", wrCount - w0, 0);
    frame(2'b01, 5'b10_101, 5'b01100, 16'h1234, 32, rd, ta, oe);
    chk("R5 one write on lower half", wrCount - w0, 1);
    chk("R5 joined data", lastWrData, 32'hBEEF1234);
    chk("R2 R3 write address", {13'd0, lastWrAddr}, {13'd0, 10'h2A5, 3'b101, 4'b0110, 2'b00});
  endtask

  task automatic testReads();
    logic [15:0] rd; logic ta, oe; int r0;
    busWord = 32'hCAFE5678;
    r0 = rdCount;
    frame(2'b10, 5'b10_011, 5'b00010, 16'h0, 32, rd, ta, oe);
    chk("R6 lower read data", {16'd0, rd}, 32'h5678);
    chk("R6 one bus read", rdCount - r0, 1);
    chk("R3 read address", {13'd0, lastRdAddr}, {13'd0, 10'h2A5, 3'b011, 4'b0001, 2'b00});
    chk("R12 turnaround and release", {31'd0, ta}, 32'd1);
    busWord = 32'h0;
    frame(2'b10, 5'b10_011, 5'b00011, 16'h0, 32, rd, ta, oe);
    chk("R7 upper read snapshot", {16'd0, rd}, 32'hCAFE);
    chk("R7 no bus read", rdCount - r0, 1);
  endtask

  task automatic testPageRead();
    logic [15:0] rd; logic ta, oe; int r0, w0;
    r0 = rdCount; w0 = wrCount;
    frame(2'b10, 5'b11_000, 5'd0, 16'h0, 32, rd, ta, oe);
    chk("R8 page read ones", {16'd0, rd}, 32'hFFFF);
    chk("R8 no bus access", (rdCount - r0) + (wrCount - w0), 0);
  endtask

  task automatic testBypass();
    logic [15:0] rd; logic ta, oe; int b0, w0, r0;
    b0 = bypCount; w0 = wrCount; r0 = rdCount;
    frame(2'b10, 5'b00_010, 5'd3, 16'h0, 32, rd, ta, oe);
    chk("R9 bypass read ones", {16'd0, rd}, 32'hFFFF);
    chk("R9 bypass pulse on read", bypCount - b0, 1);
    frame(2'b01, 5'b00_010, 5'd3, 16'h5555, 32, rd, ta, oe);
    chk("R9 bypass pulse on write", bypCount - b0, 2);
    chk("R9 bypass no bus access", (wrCount - w0) + (rdCount - r0), 0);
  endtask

  task automatic testIgnored();
    logic [15:0] rd; logic ta, oe; int w0, r0, b0;
    w0 = wrCount; r0 = rdCount; b0 = bypCount;
    frame(2'b10, 5'b01_000, 5'd2, 16'h0, 32, rd, ta, oe);
    chk("R1 unused mode no drive", {31'd0, oe}, 32'd0);
    chk("R1 unused mode no access", (rdCount - r0) + (bypCount - b0), 0);
    frame(2'b01, 5'b10_000, 5'b00000, 16'h7777, 20, rd, ta, oe);
    chk("R11 short preamble ignored", wrCount - w0, 0);
    frame(2'b11, 5'b10_000, 5'b00000, 16'h7777, 32, rd, ta, oe);
    chk("R11 bad opcode ignored", {31'd0, oe} + (wrCount - w0), 0);
  endtask

  task automatic testResetClears();
    logic [15:0] rd; logic ta, oe; int w0;
    frame(2'b01, 5'b11_000, 5'd0, 16'h03FF, 32, rd, ta, oe);
    frame(2'b01, 5'b10_001, 5'b00001, 16'hABCD, 32, rd, ta, oe);
    doReset();
    w0 = wrCount;
    frame(2'b01, 5'b10_001, 5'b00000, 16'h4321, 32, rd, ta, oe);
    chk("R10 write after reset", wrCount - w0, 1);
    chk("R10 page cleared", {13'd0, lastWrAddr}, {13'd0, 10'h000, 3'b001, 4'b0000, 2'b00});
    chk("R10 hold cleared", lastWrData, 32'h00004321);
  endtask

  initial begin
    testReset();
    testSplitWrite();
    testReads();
    testPageRead();
    testBypass();
    testIgnored();
    testResetClears();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule